// File: doc/BRIEF.md
# Three-Lane Symbol Deskew Buffer

This block takes three 10-bit symbol streams that have each been word-aligned on their own, in the pixel clock domain. Because the lanes travel over separate paths, the same symbol can reach this block on different lanes up to one pixel clock apart. The block delivers the three streams in lockstep, one symbol per lane per clock, together with a single flag that says the lanes are lined up.

Each lane watches for the point where the link moves from ordinary data into blanking. That point is the first control token that follows a non-control symbol. The block then compares when each lane reached it. A lane that got there one clock ahead of the others is read from the far end of its two-entry delay line, so all three blanking edges leave together. The chosen delays stay in place for as long as every lane stays valid. Each later blanking start is measured again. A spread wider than one clock, or an edge seen on only one or two lanes, withdraws the aligned flag until the next blanking start that lines up.

Top module: `tmds_lane_deskew`

## Requirements
- R1: The control tokens are the four 10-bit codes 0x354, 0x0AB, 0x154 and 0x2AB. A lane sees a blanking edge in a cycle where its valid is high, its symbol is one of these codes, and its previous valid symbol was not a control token. The first symbol after the lane's valid rises never counts as an edge.
- R2: A lane with no extra delay presents its input symbol on its output slice (bits 10*i+9 down to 10*i) one clock later. A lane given extra delay presents it two clocks later.
- R3: When the lane edges fall in two adjacent cycles, the lanes that saw the edge first get one clock of extra delay. After that, each output slice shows the same source symbol index on every lane.
- R4: When all three lanes see the edge in the same cycle, no lane gets extra delay. The aligned flag is high in the cycle after the edge.
- R5: If the edges do not all fall within two adjacent cycles, the aligned flag is low in the cycle after the two-cycle window closes. This includes an edge on only some lanes. Alignment is tried again at the next blanking start.
- R6: out_vld is high only when all three lane valids were high in the previous cycle and a successful alignment has happened since they last rose.
- R7: If any lane valid is low in a cycle, out_vld is low in the next cycle.
- R8: While every lane valid stays high and the lane skew does not change, out_vld stays high through later blanking intervals.
- R9: During reset, out_vld and out_sym are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_vld | input | 3 | Per-lane word-locked and symbol-valid |
| lane_sym | input | 30 | Lane symbols, lane i in bits 10*i+9:10*i |
| out_sym | output | 30 | Co-timed lane symbols, same packing |
| out_vld | output | 1 | Lanes aligned and all valid |

## Verification
The edge-agreement property assumes two things. First, the lane skew changes only while some lane is invalid. Second, a control token inside active data shows up as an isolated edge, not as a real blanking start on all lanes. The stimulus builds one common frame of data and blanking segments. Each lane is offset by its own skew, and the skew changes only in the gaps between link sessions. The one lone token inside active data is a directed glitch, and it is expected to drop the aligned flag before the next blanking start restores it.

// File: rtl/tmds_dsk_pkg.sv
`timescale 1ns/1ps
package tmds_dsk_pkg;
   localparam int unsigned TOKEN_W = 10;

   // Recognises the four transition-rich blanking codes.
   function automatic logic is_blank_token(input logic [TOKEN_W-1:0] s);
      return (s == 10'h354) || (s == 10'h0AB) || (s == 10'h154) || (s == 10'h2AB);
   endfunction
endpackage

// File: rtl/dsk_lane.sv
`timescale 1ns/1ps
module dsk_lane #(
   parameter int unsigned SYM_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic [SYM_W-1:0] sym_in,
   input  logic             sel,
   output logic             mark,
   output logic [SYM_W-1:0] sym_out
);
   import tmds_dsk_pkg::*;

   logic             prev_ctl;
   logic             cur_ctl;
   logic [SYM_W-1:0] tap_near;
   logic [SYM_W-1:0] tap_far;

   assign cur_ctl = is_blank_token(sym_in);
   assign mark    = vld & cur_ctl & ~prev_ctl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_ctl <= 1'b1;
         tap_near <= '0;
         tap_far  <= '0;
      end else begin
         // An invalid cycle poisons the history so no edge is seen on re-lock.
         prev_ctl <= vld ? cur_ctl : 1'b1;
         tap_near <= sym_in;
         tap_far  <= tap_near;
      end
   end

   assign sym_out = sel ? tap_far : tap_near;
endmodule

// File: rtl/dsk_align.sv
`timescale 1ns/1ps
module dsk_align #(
   parameter int unsigned LANES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             all_vld,
   input  logic [LANES-1:0] mark,
   output logic [LANES-1:0] sel,
   output logic             aligned,
   output logic             win_open,
   output logic [LANES-1:0] win_first
);
   localparam logic [LANES-1:0] ALL_SET = {LANES{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_open  <= 1'b0;
         win_first <= '0;
         sel       <= '0;
         aligned   <= 1'b0;
      end else if (!all_vld) begin
         win_open <= 1'b0;
         aligned  <= 1'b0;
      end else if (win_open) begin
         win_open <= 1'b0;
         if ((win_first | mark) == ALL_SET) begin
            sel     <= win_first;
            aligned <= 1'b1;
         end else begin
            aligned <= 1'b0;
         end
      end else if (|mark) begin
         if (mark == ALL_SET) begin
            sel     <= '0;
            aligned <= 1'b1;
         end else begin
            win_open  <= 1'b1;
            win_first <= mark;
         end
      end
   end
endmodule

// File: rtl/tmds_lane_deskew.sv
`timescale 1ns/1ps
module tmds_lane_deskew #(
   parameter int unsigned LANES = 3,
   parameter int unsigned SYM_W = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LANES-1:0]       lane_vld,
   input  logic [LANES*SYM_W-1:0] lane_sym,
   output logic [LANES*SYM_W-1:0] out_sym,
   output logic                   out_vld
);
   localparam int unsigned BUS_W = LANES * SYM_W;

   generate
      if (SYM_W != tmds_dsk_pkg::TOKEN_W) begin : g_bad_width
         $error("SYM_W must equal the 10-bit token width");
      end
      if (LANES < 2) begin : g_bad_lanes
         $error("LANES must be at least 2");
      end
   endgenerate

   logic [LANES-1:0] mark;
   logic [LANES-1:0] sel;
   logic [LANES-1:0] win_first;
   logic             win_open;
   logic             aligned;
   logic [BUS_W-1:0] lane_out;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         dsk_lane #(.SYM_W(SYM_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld     (lane_vld[i]),
            .sym_in  (lane_sym[i*SYM_W +: SYM_W]),
            .sel     (sel[i]),
            .mark    (mark[i]),
            .sym_out (lane_out[i*SYM_W +: SYM_W])
         );
      end
   endgenerate

   dsk_align #(.LANES(LANES)) u_align (
      .clk       (clk),
      .rst_n     (rst_n),
      .all_vld   (&lane_vld),
      .mark      (mark),
      .sel       (sel),
      .aligned   (aligned),
      .win_open  (win_open),
      .win_first (win_first)
   );

   assign out_sym = lane_out;
   assign out_vld = aligned;
endmodule

// File: rtl/tmds_lane_deskew_chk.sv
`timescale 1ns/1ps
module tmds_lane_deskew_chk #(
   parameter int unsigned LANES = 3,
   parameter int unsigned SYM_W = 10
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [LANES-1:0]       lane_vld,
   input logic [LANES*SYM_W-1:0] out_sym,
   input logic                   out_vld,
   input logic [LANES-1:0]       sel,
   input logic [LANES-1:0]       mark,
   input logic                   win_open,
   input logic [LANES-1:0]       win_first
);
   import tmds_dsk_pkg::*;
   localparam logic [LANES-1:0] ALL_SET = {LANES{1'b1}};

   logic [LANES-1:0] oc;
   logic [LANES-1:0] oc_q;

   always_comb begin
      for (int i = 0; i < LANES; i++) oc[i] = is_blank_token(out_sym[i*SYM_W +: SYM_W]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) oc_q <= ALL_SET;
      else        oc_q <= oc;
   end

   AST_EDGE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && |(oc & ~oc_q)) |=> (!out_vld || $past(&oc))); // R3
   AST_LATE_NOT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (sel != ALL_SET)); // R3
   AST_EVEN_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (&lane_vld && !win_open && mark == ALL_SET) |=> (out_vld && sel == '0)); // R4
   AST_SPREAD_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (&lane_vld && win_open && ((win_first | mark) != ALL_SET)) |=> !out_vld); // R5
   AST_VLD_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(&lane_vld)); // R6
   AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !(&lane_vld) |=> !out_vld); // R7
endmodule

bind tmds_lane_deskew tmds_lane_deskew_chk #(.LANES(LANES), .SYM_W(SYM_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lane_vld  (lane_vld),
   .out_sym   (out_sym),
   .out_vld   (out_vld),
   .sel       (sel),
   .mark      (mark),
   .win_open  (win_open),
   .win_first (win_first)
);

// File: tb/tmds_lane_deskew_test.sv
`timescale 1ns/1ps
module tmds_lane_deskew_test;
   localparam int LANES = 3;
   localparam int SYM_W = 10;

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic [LANES-1:0]       lane_vld;
   logic [LANES*SYM_W-1:0] lane_sym;
   logic [LANES*SYM_W-1:0] out_sym;
   logic                   out_vld;

   always #2 clk = ~clk;

   tmds_lane_deskew #(.LANES(LANES), .SYM_W(SYM_W)) uut (
      .clk(clk), .rst_n(rst_n), .lane_vld(lane_vld), .lane_sym(lane_sym),
      .out_sym(out_sym), .out_vld(out_vld)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [SYM_W-1:0] hist [LANES][16];
   int skew [LANES];
   int maxs, cyc, ph_cnt, dlen, blen, seg;
   bit active, legal, glitch_en, all_eq;
   logic [LANES-1:0] vmask;

   int    pend_p [8];
   bit    pend_v [8];
   string pend_r [8];
   bit    pend_use [8];

   function automatic bit is_ctl(input logic [SYM_W-1:0] s);
      return (s == 10'h354) || (s == 10'h0AB) || (s == 10'h154) || (s == 10'h2AB);
   endfunction

   function automatic logic [SYM_W-1:0] ctl_code(input int n);
      case (n % 4)
         0: return 10'h354;
         1: return 10'h0AB;
         2: return 10'h154;
         default: return 10'h2AB;
      endcase
   endfunction

   function automatic logic [SYM_W-1:0] rnd_data();
      logic [SYM_W-1:0] v;
      v = SYM_W'($urandom);
      if (is_ctl(v)) v = v ^ 10'h001;
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic schedule(input int p, input bit v, input string r);
      for (int k = 0; k < 8; k++) begin
         if (!pend_use[k]) begin
            pend_use[k] = 1; pend_p[k] = p; pend_v[k] = v; pend_r[k] = r;
            return;
         end
      end
   endtask

   task automatic step();
      int p;
      logic [SYM_W-1:0] a, e;
      bit blank;
      @(negedge clk);
      p = cyc - 1;
      if (out_vld === 1'b1) begin
         for (int i = 0; i < LANES; i++) begin
            a = out_sym[i*SYM_W +: SYM_W];
            e = hist[i][(p - maxs) & 15];
            check(a === e, all_eq ? "R2 R4 lane data" : "R2 R3 lane data", 32'(a), 32'(e));
         end
      end
      for (int k = 0; k < 8; k++) begin
         if (pend_use[k] && pend_p[k] == p) begin
            check(out_vld === pend_v[k], pend_r[k], 32'(out_vld), 32'(pend_v[k]));
            pend_use[k] = 0;
         end
      end
      if (active) begin
         blank = (ph_cnt >= dlen);
         if (ph_cnt == dlen) schedule(cyc + 3, legal, legal ? (seg == 0 ? "R1 R6 first align" : "R8 hold") : "R5 wide spread");
         for (int i = 0; i < LANES; i++) hist[i][cyc & 15] = blank ? ctl_code(int'($urandom % 4)) : rnd_data();
         if (glitch_en && seg == 1 && ph_cnt == 3) begin
            hist[0][cyc & 15] = ctl_code(0);
            schedule(cyc + skew[0] + 2, 1'b0, "R5 lone edge");
         end
         ph_cnt++;
         if (ph_cnt == dlen + blen) begin
            ph_cnt = 0; seg++;
            dlen = 8 + int'($urandom % 8);
            blen = 5 + int'($urandom % 6);
         end
      end else begin
         for (int i = 0; i < LANES; i++) hist[i][cyc & 15] = rnd_data();
      end
      for (int i = 0; i < LANES; i++) lane_sym[i*SYM_W +: SYM_W] = hist[i][(cyc - skew[i]) & 15];
      lane_vld = vmask;
      cyc++;
   endtask

   initial begin
      int mn, seed;
      seed = int'($urandom(32'h5EED));
      for (int i = 0; i < LANES; i++) begin
         skew[i] = 0;
         for (int j = 0; j < 16; j++) hist[i][j] = rnd_data();
      end
      for (int k = 0; k < 8; k++) pend_use[k] = 0;
      maxs = 0; cyc = 0; active = 0; vmask = '0; all_eq = 1;
      rst_n = 1'b0; lane_vld = '0; lane_sym = '0;
      for (int n = 0; n < 3; n++) step();
      check(out_vld === 1'b0, "R9 reset vld", 32'(out_vld), 0);
      check(out_sym === '0, "R9 reset data", out_sym[31:0], 0);
      rst_n = 1'b1;
      for (int n = 0; n < 3; n++) step();

      for (int s = 0; s < 12; s++) begin
         if (s == 1)      begin skew[0] = 0; skew[1] = 1; skew[2] = 1; end
         else if (s == 2) begin skew[0] = 0; skew[1] = 0; skew[2] = 2; end
         else if (s == 4) begin skew[0] = 1; skew[1] = 1; skew[2] = 1; end
         else begin
            int base;
            base = int'($urandom % 2);
            for (int i = 0; i < LANES; i++) skew[i] = base + int'($urandom % 2);
         end
         maxs = 0; mn = 9;
         for (int i = 0; i < LANES; i++) begin
            if (skew[i] > maxs) maxs = skew[i];
            if (skew[i] < mn) mn = skew[i];
         end
         legal     = (maxs - mn) <= 1;
         all_eq    = (maxs == mn);
         glitch_en = legal && (s == 5 || s == 8);
         ph_cnt = 0; seg = 0;
         dlen = 8 + int'($urandom % 8);
         blen = 5 + int'($urandom % 6);
         active = 1; vmask = '1;
         schedule(cyc + 2, 1'b0, "R6 no deskew yet");
         while (seg < 3) step();
         if (s % 3 == 2) vmask = 3'b101;
         else            vmask = '0;
         active = 0;
         schedule(cyc, 1'b0, "R7 valid drop");
         for (int n = 0; n < 4; n++) step();
      end
      step(); step();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule